// File: doc/BRIEF.md
# Banked GPIO Port Register File

This block keeps the per-pin state of a wide general-purpose I/O port that is split into equal banks. Every bank holds five byte-wide registers: a sampled copy of the pin levels, an output latch, a read-inversion mask, a direction mask and an interrupt mask. A serial-bus front end hands the block a bank index, a register selector and a data byte. It reads back through the same selector. The block drives the pin output values and per-pin output enables.

Writes are staged. A written byte waits in a single pending slot and only changes a register when the front end pulses the acknowledge strobe that follows the data byte. So pins move at the acknowledge, not while the byte is being shifted. Pin levels pass through a multi-flop synchronizer before they are stored. An active-low external enable can float every driven pin at once, for example to blink or dim LEDs with a PWM signal.

Top module: `gpio_bank_regs`

## Requirements
- R1: While reset is asserted and on leaving it, every pin is an input (all `pin_oe` low). All direction bits are 1. The output latch, polarity and mask registers are all zero.
- R2: `reg_sel` encodes 0 = input value, 1 = output latch, 2 = polarity, 3 = direction, 4 = mask. Bit b of bank k's byte belongs to pin k*BANK_W+b.
- R3: `pin_oe` of a pin is high only when its direction bit is 0 and `oe_n` is low. Output latch bits of pins whose direction bit is 1 never drive a pin.
- R4: A write changes no register and no pin until the next `ack` pulse. It takes effect on the clock edge that samples `ack` high.
- R5: A second write before `ack` replaces the pending one. An `ack` with nothing pending changes nothing.
- R6: `rd_data` shows the selected register on the clock after `rd_en` is high, and is zero after a cycle without `rd_en`.
- R7: The stored input value equals `pin_in` after SYNC_STAGES+1 clock edges, whatever the direction of the pin. Reading it returns that value XOR the polarity byte.
- R8: Reading the output latch returns the latch contents, not the level on the pin.
- R9: Writes with selector 0, selector above 4 or a bank index at or above NUM_BANKS change nothing. Reads with selector above 4 or such a bank index return zero.
- R10: With `oe_n` high every `pin_oe` is low. The latches keep their values, and driving resumes when `oe_n` returns low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Stage a write of `wr_data` |
| rd_en | input | 1 | Read request |
| bank_idx | input | BIDX_W | Bank number for the read or write |
| reg_sel | input | 3 | Register selector |
| wr_data | input | BANK_W | Byte to write |
| ack | input | 1 | Acknowledge strobe committing the pending write |
| oe_n | input | 1 | Active-low enable for all driven pins |
| pin_in | input | NUM_BANKS*BANK_W | Raw pin levels |
| pin_out | output | NUM_BANKS*BANK_W | Output latch values toward the pads |
| pin_oe | output | NUM_BANKS*BANK_W | Per-pin drive enable |
| rd_data | output | BANK_W | Registered read data |

## Verification
The bench builds the block with its defaults: five banks of eight pins and a two-flop synchronizer. With five banks the three-bit bank index can also carry 5, 6 and 7, so writes and reads to absent banks can be driven at the ports. The input-value latency of three edges is probed with back-to-back reads. A behavioural model of the pending slot, the synchronizer pipeline and the registered read port is compared against every output on every clock.

// File: rtl/gpio_pkg.sv
`timescale 1ns/1ps
package gpio_pkg;
   localparam int SEL_W = 3;

   typedef enum logic [SEL_W-1:0] {
      REG_IN  = 3'd0,
      REG_OUT = 3'd1,
      REG_POL = 3'd2,
      REG_DIR = 3'd3,
      REG_MSK = 3'd4
   } gpio_reg_e;
endpackage

// File: rtl/gpio_sync.sv
`timescale 1ns/1ps
module gpio_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES == 0) begin : g_bypass
      assign q = d;
   end else begin : g_chain
      logic [W-1:0] stage_q [STAGES];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stage_q[0] <= '0;
         else        stage_q[0] <= d;
      end

      for (genvar s = 1; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
         end
      end

      assign q = stage_q[STAGES-1];
   end
endmodule

// File: rtl/gpio_wr_stage.sv
`timescale 1ns/1ps
module gpio_wr_stage
   import gpio_pkg::*;
#(
   parameter int NUM_BANKS = 5,
   parameter int BANK_W    = 8,
   parameter int BIDX_W    = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [BIDX_W-1:0]    wr_bank,
   input  gpio_reg_e            wr_sel,
   input  logic [BANK_W-1:0]    wr_data,
   input  logic                 ack,
   output logic [NUM_BANKS-1:0] commit_en,
   output gpio_reg_e            commit_sel,
   output logic [BANK_W-1:0]    commit_data
);
   logic              pend_v;
   logic [BIDX_W-1:0] pend_bank;
   gpio_reg_e         pend_sel;
   logic [BANK_W-1:0] pend_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_v    <= 1'b0;
         pend_bank <= '0;
         pend_sel  <= REG_IN;
         pend_data <= '0;
      end else if (wr_en) begin
         pend_v    <= 1'b1;
         pend_bank <= wr_bank;
         pend_sel  <= wr_sel;
         pend_data <= wr_data;
      end else if (ack) begin
         pend_v    <= 1'b0;
      end
   end

   for (genvar g = 0; g < NUM_BANKS; g++) begin : g_dec
      assign commit_en[g] = ack && pend_v && (pend_bank == BIDX_W'(g));
   end

   assign commit_sel  = pend_sel;
   assign commit_data = pend_data;
endmodule

// File: rtl/gpio_bank.sv
`timescale 1ns/1ps
module gpio_bank
   import gpio_pkg::*;
#(
   parameter int BANK_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              commit,
   input  gpio_reg_e         sel,
   input  logic [BANK_W-1:0] data,
   input  logic [BANK_W-1:0] in_sample,
   output logic [BANK_W-1:0] out_q,
   output logic [BANK_W-1:0] dir_q,
   output logic [BANK_W-1:0] pol_q,
   output logic [BANK_W-1:0] msk_q,
   output logic [BANK_W-1:0] in_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q <= '0;
         dir_q <= '1;
         pol_q <= '0;
         msk_q <= '0;
         in_q  <= '0;
      end else begin
         in_q <= in_sample;
         if (commit) begin
            case (sel)
               REG_OUT: out_q <= data;
               REG_POL: pol_q <= data;
               REG_DIR: dir_q <= data;
               REG_MSK: msk_q <= data;
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/gpio_bank_regs.sv
`timescale 1ns/1ps
module gpio_bank_regs
   import gpio_pkg::*;
#(
   parameter  int NUM_BANKS   = 5,
   parameter  int BANK_W      = 8,
   parameter  int SYNC_STAGES = 2,
   localparam int NPINS       = NUM_BANKS * BANK_W,
   localparam int BIDX_W      = $clog2(NUM_BANKS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [BIDX_W-1:0] bank_idx,
   input  logic [2:0]        reg_sel,
   input  logic [BANK_W-1:0] wr_data,
   input  logic              ack,
   input  logic              oe_n,
   input  logic [NPINS-1:0]  pin_in,
   output logic [NPINS-1:0]  pin_out,
   output logic [NPINS-1:0]  pin_oe,
   output logic [BANK_W-1:0] rd_data
);
   if (NUM_BANKS < 1) begin : g_bad_banks
      $error("gpio_bank_regs: NUM_BANKS must be at least 1");
   end
   if (BANK_W < 1) begin : g_bad_width
      $error("gpio_bank_regs: BANK_W must be at least 1");
   end
   if (SYNC_STAGES < 0) begin : g_bad_sync
      $error("gpio_bank_regs: SYNC_STAGES must not be negative");
   end

   gpio_reg_e              sel_e;
   logic [NPINS-1:0]       pin_sync;
   logic [NUM_BANKS-1:0]   commit_en;
   gpio_reg_e              commit_sel;
   logic [BANK_W-1:0]      commit_data;
   logic [BANK_W-1:0]      out_a [NUM_BANKS];
   logic [BANK_W-1:0]      dir_a [NUM_BANKS];
   logic [BANK_W-1:0]      pol_a [NUM_BANKS];
   logic [BANK_W-1:0]      msk_a [NUM_BANKS];
   logic [BANK_W-1:0]      in_a  [NUM_BANKS];
   logic [BANK_W-1:0]      rd_val;

   assign sel_e = gpio_reg_e'(reg_sel);

   gpio_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (pin_sync)
   );

   gpio_wr_stage #(
      .NUM_BANKS (NUM_BANKS),
      .BANK_W    (BANK_W),
      .BIDX_W    (BIDX_W)
   ) u_wr (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (wr_en),
      .wr_bank     (bank_idx),
      .wr_sel      (sel_e),
      .wr_data     (wr_data),
      .ack         (ack),
      .commit_en   (commit_en),
      .commit_sel  (commit_sel),
      .commit_data (commit_data)
   );

   for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
      gpio_bank #(.BANK_W(BANK_W)) u_bank (
         .clk       (clk),
         .rst_n     (rst_n),
         .commit    (commit_en[g]),
         .sel       (commit_sel),
         .data      (commit_data),
         .in_sample (pin_sync[g*BANK_W +: BANK_W]),
         .out_q     (out_a[g]),
         .dir_q     (dir_a[g]),
         .pol_q     (pol_a[g]),
         .msk_q     (msk_a[g]),
         .in_q      (in_a[g])
      );

      assign pin_out[g*BANK_W +: BANK_W] = out_a[g];
      assign pin_oe [g*BANK_W +: BANK_W] = ~dir_a[g] & {BANK_W{~oe_n}};
   end

   always_comb begin
      rd_val = '0;
      for (int b = 0; b < NUM_BANKS; b++) begin
         if (bank_idx == BIDX_W'(b)) begin
            case (sel_e)
               REG_IN:  rd_val = in_a[b] ^ pol_a[b];
               REG_OUT: rd_val = out_a[b];
               REG_POL: rd_val = pol_a[b];
               REG_DIR: rd_val = dir_a[b];
               REG_MSK: rd_val = msk_a[b];
               default: rd_val = '0;
            endcase
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rd_data <= '0;
      else if (rd_en) rd_data <= rd_val;
      else            rd_data <= '0;
   end
endmodule

// File: rtl/gpio_bank_regs_chk.sv
`timescale 1ns/1ps
module gpio_bank_regs_chk #(
   parameter  int NUM_BANKS = 5,
   parameter  int BANK_W    = 8,
   localparam int NPINS     = NUM_BANKS * BANK_W,
   localparam int BIDX_W    = $clog2(NUM_BANKS + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rd_en,
   input logic [BIDX_W-1:0] bank_idx,
   input logic              ack,
   input logic              oe_n,
   input logic [NPINS-1:0]  pin_out,
   input logic [NPINS-1:0]  pin_oe,
   input logic [BANK_W-1:0] rd_data
);
   // R1: first edge after reset leaves every pin undriven
   a_r1_reset_all_inputs: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> pin_oe == '0);

   // R4: pin values move only on an acknowledge edge
   a_r4_pins_move_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(ack) |-> $stable(pin_out));

   // R6: no request, no read data
   a_r6_idle_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rd_en) |-> rd_data == '0);

   // R9: absent bank reads as zero
   a_r9_absent_bank_zero: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rd_en) && ($past(bank_idx) >= BIDX_W'(NUM_BANKS))) |-> rd_data == '0);

   // R10: external enable high floats every pin
   a_r10_oe_n_floats: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n |-> pin_oe == '0);
endmodule

bind gpio_bank_regs gpio_bank_regs_chk #(
   .NUM_BANKS (NUM_BANKS),
   .BANK_W    (BANK_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .rd_en    (rd_en),
   .bank_idx (bank_idx),
   .ack      (ack),
   .oe_n     (oe_n),
   .pin_out  (pin_out),
   .pin_oe   (pin_oe),
   .rd_data  (rd_data)
);

// File: tb/gpio_bank_regs_tb.sv
`timescale 1ns/1ps
module gpio_bank_regs_tb;
   localparam int NB = 5;
   localparam int BW = 8;
   localparam int NP = NB * BW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic          rd_en = 1'b0;
   logic [2:0]    bank_idx = '0;
   logic [2:0]    reg_sel = '0;
   logic [7:0]    wr_data = '0;
   logic          ack = 1'b0;
   logic          oe_n = 1'b0;
   logic [NP-1:0] pin_in = '0;
   logic [NP-1:0] pin_out;
   logic [NP-1:0] pin_oe;
   logic [7:0]    rd_data;

   int  checks = 0;
   int  fails  = 0;
   bit  done   = 0;

   always #4 clk = ~clk;

   gpio_bank_regs u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
      .bank_idx(bank_idx), .reg_sel(reg_sel), .wr_data(wr_data),
      .ack(ack), .oe_n(oe_n), .pin_in(pin_in), .pin_out(pin_out),
      .pin_oe(pin_oe), .rd_data(rd_data)
   );

   // behavioural reference model
   logic [7:0]    m_out [NB];
   logic [7:0]    m_dir [NB];
   logic [7:0]    m_pol [NB];
   logic [7:0]    m_msk [NB];
   logic [7:0]    m_in  [NB];
   logic [NP-1:0] m_pipe [$];
   bit            m_pv;
   int            m_pb, m_ps;
   logic [7:0]    m_pd;
   logic [7:0]    m_rd;

   function automatic logic [7:0] m_read(int b, int s);
      if (b >= NB) return 8'h00;
      case (s)
         0: return m_in[b] ^ m_pol[b];
         1: return m_out[b];
         2: return m_pol[b];
         3: return m_dir[b];
         4: return m_msk[b];
         default: return 8'h00;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int b = 0; b < NB; b++) begin
            m_out[b] = 8'h00; m_dir[b] = 8'hFF; m_pol[b] = 8'h00;
            m_msk[b] = 8'h00; m_in[b] = 8'h00;
         end
         m_pipe = {};
         m_pipe.push_back('0);
         m_pipe.push_back('0);
         m_pv = 0; m_pb = 0; m_ps = 0; m_pd = 0; m_rd = 0;
      end else begin
         logic [7:0]    nrd;
         logic [NP-1:0] oldest;
         nrd = rd_en ? m_read(int'(bank_idx), int'(reg_sel)) : 8'h00;
         if (ack && m_pv && m_pb < NB) begin
            case (m_ps)
               1: m_out[m_pb] = m_pd;
               2: m_pol[m_pb] = m_pd;
               3: m_dir[m_pb] = m_pd;
               4: m_msk[m_pb] = m_pd;
               default: ;
            endcase
         end
         if (ack) m_pv = 0;
         if (wr_en) begin
            m_pv = 1; m_pb = int'(bank_idx); m_ps = int'(reg_sel); m_pd = wr_data;
         end
         oldest = m_pipe.pop_front();
         for (int b = 0; b < NB; b++) m_in[b] = oldest[b*BW +: BW];
         m_pipe.push_back(pin_in);
         m_rd = nrd;
      end
   end

   task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         logic [NP-1:0] e_out, e_oe;
         for (int b = 0; b < NB; b++) begin
            e_out[b*BW +: BW] = m_out[b];
            e_oe [b*BW +: BW] = ~m_dir[b] & {BW{~oe_n}};
         end
         chk("R4 per-cycle pin_out", 64'(pin_out), 64'(e_out));
         chk("R3 per-cycle pin_oe", 64'(pin_oe), 64'(e_oe));
         chk("R6 per-cycle rd_data", 64'(rd_data), 64'(m_rd));
      end
   end

   task automatic wr(int b, int s, logic [7:0] d);
      wr_en = 1; bank_idx = 3'(b); reg_sel = 3'(s); wr_data = d;
      @(posedge clk); #2;
      wr_en = 0;
   endtask

   task automatic pulse_ack();
      ack = 1;
      @(posedge clk); #2;
      ack = 0;
   endtask

   task automatic rd(int b, int s, output logic [7:0] v);
      rd_en = 1; bank_idx = 3'(b); reg_sel = 3'(s);
      @(posedge clk); #2;
      rd_en = 0;
      v = rd_data;
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #2;
      end
   endtask

   initial begin
      logic [7:0] v;
      idle(3);
      rst_n = 1;
      idle(1);
      chk("R1 pin_oe after reset", 64'(pin_oe), 64'h0);
      rd(0, 3, v); chk("R1 direction reset", 64'(v), 64'hFF);
      rd(2, 1, v); chk("R1 latch reset", 64'(v), 64'h00);
      rd(4, 2, v); chk("R1 polarity reset", 64'(v), 64'h00);

      wr(0, 3, 8'h00);
      chk("R4 direction pending before ack", 64'(pin_oe), 64'h0);
      pulse_ack();
      chk("R3 bank0 driven", 64'(pin_oe), 64'h00_00_00_00_FF);

      wr(0, 1, 8'hA5);
      chk("R4 latch pending before ack", 64'(pin_out[7:0]), 64'h00);
      pulse_ack();
      chk("R4 latch after ack", 64'(pin_out[7:0]), 64'hA5);

      wr(1, 1, 8'h3C);
      wr(1, 1, 8'hC3);
      pulse_ack();
      chk("R5 last write wins", 64'(pin_out[15:8]), 64'hC3);
      pulse_ack();
      chk("R5 empty ack no change", 64'(pin_out[15:8]), 64'hC3);
      chk("R3 latch on input pins not driven", 64'(pin_oe[15:8]), 64'h00);

      rd(1, 1, v); chk("R6 read latch", 64'(v), 64'hC3);
      idle(1);
      chk("R6 idle read zero", 64'(rd_data), 64'h00);

      oe_n = 1; idle(1);
      chk("R10 oe_n high floats", 64'(pin_oe), 64'h0);
      rd(0, 1, v); chk("R10 latch kept", 64'(v), 64'hA5);
      oe_n = 0; idle(1);
      chk("R10 oe_n low drives again", 64'(pin_oe[7:0]), 64'hFF);

      pin_in = 40'h5A_00_00_00_0F;
      idle(4);
      rd(4, 0, v); chk("R7 input bank4", 64'(v), 64'h5A);
      rd(0, 0, v); chk("R7 input on output pins", 64'(v), 64'h0F);
      wr(4, 2, 8'hFF); pulse_ack();
      rd(4, 0, v); chk("R7 polarity inverts", 64'(v), 64'hA5);

      pin_in[16] = 1'b1;
      rd(2, 0, v); chk("R7 latency edge1", 64'(v), 64'h00);
      rd(2, 0, v); chk("R7 latency edge2", 64'(v), 64'h00);
      rd(2, 0, v); chk("R7 latency edge3", 64'(v), 64'h00);
      rd(2, 0, v); chk("R7 latency edge4", 64'(v), 64'h01);

      wr(3, 1, 8'hFF); pulse_ack();
      rd(3, 1, v); chk("R8 latch not pin", 64'(v), 64'hFF);
      rd(3, 0, v); chk("R8 pin level differs", 64'(v), 64'h00);

      wr(2, 0, 8'h77); pulse_ack();
      rd(2, 0, v); chk("R9 input not writable", 64'(v), 64'h01);
      wr(6, 1, 8'hFF); pulse_ack();
      rd(6, 1, v); chk("R9 absent bank read", 64'(v), 64'h00);
      chk("R9 absent bank write no effect", 64'(pin_out), 64'h00_FF_00_C3_A5);
      rd(0, 7, v); chk("R9 bad selector read", 64'(v), 64'h00);

      wr(3, 4, 8'h81); pulse_ack();
      rd(3, 4, v); chk("R2 mask register", 64'(v), 64'h81);
      wr(2, 3, 8'hFE); pulse_ack();
      chk("R2 pin index mapping", 64'(pin_oe), 64'h00_00_01_00_FF);

      idle(2);
      done = 1;
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
   end

   initial begin
      #(8 * 100000);
      if (!done) begin
         done = 1;
         checks++;
         fails++;
         $display("FAIL watchdog (all requirements) actual=hung expected=finished");
         $display("[TB] %0d tests run, %0d failed", checks, fails);
         $finish;
      end
   end
endmodule